// File: doc/BRIEF.md
# Low-Region Memory Chip Select

This block watches bus cycles on a 20-bit byte address space and pulls an active-low chip select for those cycles that land inside a programmable block anchored at address zero. The block's size is set by a 3-bit boundary field. The valid codes are 000, 001, 011 and 111. They select 64K, 128K, 256K and 512K. The same 16-bit control word also holds an address-output disable, a pseudo-static memory enable bit (stored and read back only), a ready-mode bit and a 2-bit wait-state count.

A bus cycle is offered on a valid/ready pair. The offer is taken only while the sequencer is idle (`req_ready` high), and `req_valid` may be held as long as needed. After acceptance the cycle spends one clock in the address phase. It then spends one or more clocks in the data phase, and `cyc_done` marks the last data clock. For cycles in the region, the data phase is stretched by the programmed wait states. It is also stretched, when the ready mode requires it, until the external ready input is high. The block also produces the output enable for the address on the shared address/data lines. A strap input, sampled while reset is held, can force that enable on.

The chip select stays off after reset until the control word has been written at least once. Any write arms it.

Top module: `lowmem_csel`

## Requirements
- R1: While and right after reset, `cs_n` is 1, `req_ready` is 1, and the readback has the address-disable bit (bit 7) at 0.
- R2: Until the first write to the control word, no cycle asserts `cs_n`, whatever its address. Any write arms the chip select.
- R3: Boundary field bits 14..12 of the word select the region end: 000→0FFFFh, 001→1FFFFh, 011→3FFFFh, 111→7FFFFh. An address with bit 19 set is never in the region.
- R4: Boundary codes 010, 100, 101 and 110 select the largest valid region whose code bits they contain: 010, 100 and 110 give 64K, and 101 gives 128K.
- R5: For an in-region cycle, `cs_n` is 0 from the address-phase clock through the clock where `cyc_done` is 1, and it is 1 in the idle clock after. For out-of-region cycles it stays 1.
- R6: With the ready-mode bit (bit 2) at 1, the in-region data phase lasts exactly N+1 clocks, where N is the wait-state field (bits 1..0), and `ext_ready` is ignored.
- R7: With the ready-mode bit at 0, the in-region cycle ends on the first data clock at or after clock N that also has `ext_ready` high.
- R8: In the address-phase clock, `addr_oe` is 0 for an in-region cycle when the address-disable bit (bit 7) is 1. It is 1 when that bit is 0, and 1 for every out-of-region cycle. Outside the address phase it is 0.
- R9: If `strap_addr_keep_n` is 0 on the clock that ends reset, `addr_oe` is 1 in every address phase, regardless of bit 7.
- R10: Readback always shows bit 15 as 0 and bits 11..8 and 5..3 as 1. Bits 14..12, 7, 6, 2 and 1..0 return the last written values.
- R11: `req_ready` is 1 only while idle. An out-of-region cycle takes one address clock and one data clock, whatever `ext_ready` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_addr_keep_n | input | 1 | Strap; low at reset release forces address output on |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word readback |
| req_valid | input | 1 | Bus cycle offered |
| req_addr | input | 20 | Byte address of the offered cycle |
| req_ready | output | 1 | Sequencer idle, offer accepted on this clock |
| ext_ready | input | 1 | External ready for the data phase |
| cyc_done | output | 1 | Last data-phase clock of the current cycle |
| cs_n | output | 1 | Active-low chip select for the low region |
| addr_oe | output | 1 | Address output enable in the address phase |

## Verification
Some rules are checked by assertions on every clock: the unarmed chip select never goes low, `cs_n` holds low through a data phase until completion, completion is withheld while ready is required and low, the address phase always leads into the data phase, a strap-forced enable is always on, and written fields read back the next clock. The bench sweeps all eight boundary codes against every 64K block and the full set of wait-state, ready-mode and ready-arrival combinations. Only those sweeps can show the exact region ends, the cycle lengths and the strap behaviour across a reset.

// File: rtl/lmcs_pkg.sv
package lmcs_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2
  } phase_t;

  localparam int CFG_W = 16;
  // fixed readback pattern for the reserved positions
  localparam logic [CFG_W-1:0] RSV_ONES = 16'h0F38;
  // positions that hold writable fields
  localparam logic [CFG_W-1:0] FIELD_MASK = 16'h70C7;
endpackage

// File: rtl/lmcs_cfg_reg.sv
module lmcs_cfg_reg
  import lmcs_pkg::*;
#(
  parameter int UB_W = 3,
  parameter int WS_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output logic [UB_W-1:0]  ub,
  output logic             addr_dis,
  output logic             ready_ign,
  output logic [WS_W-1:0]  wait_cnt,
  output logic             armed,
  output logic             keep_addr
);
  localparam int UB_LSB = 12;
  localparam int DA_BIT = 7;
  localparam int PS_BIT = 6;
  localparam int RM_BIT = 2;

  logic [UB_W-1:0] ub_q;
  logic            da_q, ps_q, rm_q, arm_q, keep_q;
  logic [WS_W-1:0] ws_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ub_q   <= '0;
      da_q   <= 1'b0;
      ps_q   <= 1'b0;
      rm_q   <= 1'b0;
      ws_q   <= '0;
      arm_q  <= 1'b0;
      keep_q <= ~strap_n;
    end else if (wr_en) begin
      ub_q  <= wdata[UB_LSB +: UB_W];
      da_q  <= wdata[DA_BIT];
      ps_q  <= wdata[PS_BIT];
      rm_q  <= wdata[RM_BIT];
      ws_q  <= wdata[0 +: WS_W];
      arm_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = RSV_ONES;
    rdata[UB_LSB +: UB_W] = ub_q;
    rdata[DA_BIT] = da_q;
    rdata[PS_BIT] = ps_q;
    rdata[RM_BIT] = rm_q;
    rdata[0 +: WS_W] = ws_q;
  end

  assign ub        = ub_q;
  assign addr_dis  = da_q;
  assign ready_ign = rm_q;
  assign wait_cnt  = ws_q;
  assign armed     = arm_q;
  assign keep_addr = keep_q;

  AST_CFG_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata[0 +: WS_W] == $past(wdata[0 +: WS_W]) &&
               rdata[UB_LSB +: UB_W] == $past(wdata[UB_LSB +: UB_W]))); // R10
endmodule

// File: rtl/lmcs_decode.sv
module lmcs_decode #(
  parameter int ADDR_W    = 20,
  parameter int BLK_SHIFT = 16,
  parameter int UB_W      = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [UB_W-1:0]   ub,
  input  logic              armed,
  output logic              hit
);
  localparam int TOP_LSB = BLK_SHIFT + UB_W;

  logic [UB_W-1:0] therm;
  logic            upper_zero;

  // thermometer mask: bit i survives only if all lower code bits are set
  for (genvar i = 0; i < UB_W; i++) begin : g_therm
    assign therm[i] = &ub[i:0];
  end

  if (TOP_LSB < ADDR_W) begin : g_upper
    assign upper_zero = (addr[ADDR_W-1:TOP_LSB] == '0);
  end else begin : g_noupper
    assign upper_zero = 1'b1;
  end

  assign hit = armed && upper_zero &&
               ((addr[BLK_SHIFT +: UB_W] & ~therm) == '0);
endmodule

// File: rtl/lmcs_seq.sv
module lmcs_seq
  import lmcs_pkg::*;
#(
  parameter int WS_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            hit_in,
  input  logic [WS_W-1:0] wait_cnt,
  input  logic            ready_ign,
  input  logic            ext_ready,
  output logic            req_ready,
  output phase_t          phase,
  output logic            hit_q,
  output logic            done,
  output logic            cs_n
);
  phase_t          ph_q;
  logic            hq;
  logic [WS_W-1:0] wcnt;
  logic            waits_met;

  assign waits_met = (wcnt >= wait_cnt);
  assign done = (ph_q == PH_DATA) &&
                (!hq || (waits_met && (ready_ign || ext_ready)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      hq   <= 1'b0;
      wcnt <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (req_valid) begin
          ph_q <= PH_ADDR;
          hq   <= hit_in;
        end
        PH_ADDR: begin
          ph_q <= PH_DATA;
          wcnt <= '0;
        end
        PH_DATA: begin
          if (done) begin
            ph_q <= PH_IDLE;
            hq   <= 1'b0;
          end else if (!waits_met) begin
            wcnt <= wcnt + 1'b1;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign req_ready = (ph_q == PH_IDLE);
  assign phase     = ph_q;
  assign hit_q     = hq;
  assign cs_n      = !((ph_q != PH_IDLE) && hq);

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !done) |=> !cs_n); // R5
  AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_DATA && hq && !ready_ign && !ext_ready) |-> !done); // R7
  AST_ADDR_TO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_ADDR) |=> (ph_q == PH_DATA && !req_ready)); // R11
endmodule

// File: rtl/lowmem_csel.sv
module lowmem_csel
  import lmcs_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BLK_SHIFT = 16,
  parameter int UB_W      = 3,
  parameter int WS_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_addr_keep_n,
  input  logic              cfg_wr_en,
  input  logic [15:0]       cfg_wdata,
  output logic [15:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              ext_ready,
  output logic              cyc_done,
  output logic              cs_n,
  output logic              addr_oe
);
  logic [UB_W-1:0] ub;
  logic [WS_W-1:0] wait_cnt;
  logic            addr_dis, ready_ign, armed, keep_addr, hit, hit_q;
  phase_t          phase;

  lmcs_cfg_reg #(.UB_W(UB_W), .WS_W(WS_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .strap_n(strap_addr_keep_n),
    .wr_en(cfg_wr_en), .wdata(cfg_wdata), .rdata(cfg_rdata),
    .ub(ub), .addr_dis(addr_dis), .ready_ign(ready_ign),
    .wait_cnt(wait_cnt), .armed(armed), .keep_addr(keep_addr)
  );

  lmcs_decode #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .UB_W(UB_W)) u_dec (
    .addr(req_addr), .ub(ub), .armed(armed), .hit(hit)
  );

  lmcs_seq #(.WS_W(WS_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit_in(hit),
    .wait_cnt(wait_cnt), .ready_ign(ready_ign), .ext_ready(ext_ready),
    .req_ready(req_ready), .phase(phase), .hit_q(hit_q),
    .done(cyc_done), .cs_n(cs_n)
  );

  assign addr_oe = (phase == PH_ADDR) && !(hit_q && addr_dis && !keep_addr);

  AST_UNARMED_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> cs_n); // R2
  AST_STRAP_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_addr && req_ready) |=> (cs_n || addr_oe)); // R9
endmodule

// File: tb/lowmem_csel_tb.sv
module lowmem_csel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_ready, ext_ready, cyc_done, cs_n, addr_oe;
  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;

  initial ext_ready = 1'b0;

  always #4 clk = ~clk;

  lowmem_csel u_dut (
    .clk(clk), .rst_n(rst_n), .strap_addr_keep_n(strap_n),
    .cfg_wr_en(wr_en), .cfg_wdata(wdata), .cfg_rdata(rdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .ext_ready(ext_ready), .cyc_done(cyc_done), .cs_n(cs_n), .addr_oe(addr_oe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: act=hung exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0;
    strap_n = strap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    strap_n = 1'b1;
  endtask

  task automatic write_cfg(input logic [15:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wdata = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] cfg_word(input int ub, input int da, input int rm, input int ws);
    return 16'((ub << 12) | (da << 7) | (rm << 2) | ws);
  endfunction

  function automatic int region_blocks(input int code);
    if (code == 7) return 8;
    if ((code & 3) == 3) return 4;
    if ((code & 1) == 1) return 2;
    return 1;
  endfunction

  // runs one cycle; ready rises at data clock rdy_at; checks handshake,
  // address-phase outputs, chip select and completion clock
  task automatic run_cycle(input logic [19:0] a, input bit hit, input int ws,
                           input bit rm, input int rdy_at, input bit exp_oe,
                           input string req);
    int exp_len;
    bit seen;
    if (!hit) exp_len = 1;
    else begin
      exp_len = ws + 1;
      if (!rm && rdy_at + 1 > exp_len) exp_len = rdy_at + 1;
    end
    ext_ready = (rdy_at == 0);
    req_valid = 1'b1;
    req_addr = a;
    chk(req_ready == 1'b1, "R11 ready idle", req_ready, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(cs_n == !hit, {req, " addr-phase cs_n"}, cs_n, !hit);
    chk(addr_oe == exp_oe, {req, " addr_oe"}, addr_oe, exp_oe);
    chk(req_ready == 1'b0, "R11 busy", req_ready, 0);
    seen = 0;
    for (int k = 0; k < 10 && !seen; k++) begin
      @(negedge clk);
      ext_ready = (k >= rdy_at);
      #1;
      if (cyc_done !== (k == exp_len - 1) || cs_n !== !hit) begin
        chk(0, {req, " data phase"}, {cyc_done, cs_n}, {k == exp_len - 1, !hit});
        seen = 1;
      end else if (cyc_done) begin
        seen = 1;
        chk(1, req, 0, 0);
      end
      if (k == 0 && !hit) chk(addr_oe == 0, "R8 oe off in data", addr_oe, 0);
    end
    if (!seen) chk(0, {req, " no completion"}, 0, exp_len);
    @(negedge clk);
    ext_ready = 1'b0;
    chk(cs_n == 1'b1 && req_ready == 1'b1, "R5 idle after", {cs_n, req_ready}, 3);
  endtask

  initial begin
    do_reset(1'b1);
    #1;
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk((rdata & 16'h8FB8) == 16'h0F38, "R1 readback", rdata & 16'h8FB8, 16'h0F38);

    // R2 unarmed: every 64K block misses
    for (int b = 0; b < 16; b++)
      run_cycle(20'(b << 16), 1'b0, 0, 1'b1, 0, 1'b1, "R2 unarmed");

    // R10 readback of reserved and written fields
    foreach (wdata[i]) ;
    begin
      logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'h80C5, 16'h3A42};
      for (int p = 0; p < 4; p++) begin
        write_cfg(pats[p]);
        chk(rdata == ((pats[p] & 16'h70C7) | 16'h0F38), "R10 readback",
            rdata, (pats[p] & 16'h70C7) | 16'h0F38);
      end
    end

    // R3/R4 sweep all boundary codes over all 64K blocks and block edges
    for (int code = 0; code < 8; code++) begin
      write_cfg(cfg_word(code, 0, 1, 0));
      for (int b = 0; b < 16; b++) begin
        for (int e = 0; e < 2; e++) begin
          logic [19:0] a;
          bit h;
          a = 20'((b << 16) | (e ? 16'hFFFF : 16'h0000));
          h = (int'(a) < region_blocks(code) * 65536);
          run_cycle(a, h, 0, 1'b1, 0, 1'b1,
                    (code == 0 || code == 1 || code == 3 || code == 7) ? "R3 decode" : "R4 odd code");
        end
      end
    end

    // R6/R7 wait states and ready mode
    for (int ws = 0; ws < 4; ws++)
      for (int rm = 0; rm < 2; rm++)
        for (int ra = 0; ra < 6; ra++) begin
          write_cfg(cfg_word(7, 0, rm, ws));
          run_cycle(20'h12340, 1'b1, ws, rm[0], ra, 1'b1, rm ? "R6 waits" : "R7 ready");
        end
    // R11 out-of-region ignores ready mode and waits
    write_cfg(cfg_word(0, 0, 0, 3));
    run_cycle(20'h90000, 1'b0, 3, 1'b0, 8, 1'b1, "R11 miss");

    // R8 address disable
    write_cfg(cfg_word(7, 1, 1, 1));
    run_cycle(20'h00010, 1'b1, 1, 1'b1, 0, 1'b0, "R8 da=1 hit");
    run_cycle(20'h80010, 1'b0, 1, 1'b1, 0, 1'b1, "R8 da=1 miss");
    write_cfg(cfg_word(7, 0, 1, 1));
    run_cycle(20'h00010, 1'b1, 1, 1'b1, 0, 1'b1, "R8 da=0 hit");

    // R9 strap forces address output
    do_reset(1'b0);
    write_cfg(cfg_word(7, 1, 1, 2));
    run_cycle(20'h40000, 1'b1, 2, 1'b1, 0, 1'b1, "R9 strap");
    do_reset(1'b1);
    write_cfg(cfg_word(7, 1, 1, 2));
    run_cycle(20'h40000, 1'b1, 2, 1'b1, 0, 1'b0, "R9 no strap");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule